// File: doc/BRIEF.md
# Banked Single-Port Memory Conflict Arbiter

This block connects a small pipelined core to a group of single-port RAM banks, each bank answering one fixed, contiguous address window. In any cycle the core may present up to three accesses: an instruction fetch, a data-side operand access (read or write) and a program-side operand read. The block maps every address to its bank, lets each bank serve at most one access per cycle, and when two or more accesses want the same bank it serves them over several cycles while holding a stall line high toward the pipeline.

While the stall line is high the core keeps all of its requests unchanged. The block remembers which of them it has already served and drops them when the stall falls. Read data comes back one cycle after the grant, on the port that asked for it, with a valid flag. An address that lies in no bank window gets an error flag and is never granted. When the core is repeating a single instruction, it asserts a repeat input and the fetch request is ignored, so the opcode fetch cannot collide with operand traffic.

Top module: `bkarb_top`

## Requirements
- R1: With default parameters, bank i (i = 0..3) answers addresses 0x8000 + 0x80*i through 0x8000 + 0x80*i + 0x3F, and the word offset inside the bank is the address minus the bank's base. Addresses in the gaps between windows, and outside all of them, belong to no bank.
- R2: A requested access to an address outside every bank window raises that port's error flag in the cycle after the request is first seen, with the port's valid flag low. It is never granted and never causes a stall.
- R3: No bank serves more than one access in a cycle.
- R4: When all in-range requests target different banks, they are all served in the same cycle and the stall line stays low.
- R5: When the data-side and program-side operand reads target the same bank, the data-side read is served in the first cycle and the program-side read in the next. The stall line is high for exactly the first of those cycles.
- R6: When a fetch and the data-side access target the same bank, the data-side access is served first and the fetch one cycle later, with one stall cycle.
- R7: The priority order is data-side, then program-side, then fetch. Each port is served in the cycle equal to the number of higher-priority in-range requests to its bank. The stall line is high for as many cycles as the largest such count, so three accesses to one bank give two stall cycles.
- R8: While the repeat input is high, the fetch request has no effect: no fetch grant, no fetch valid, no fetch error and no stall caused by the fetch.
- R9: Read data appears on the requesting port with its valid flag exactly one cycle after the grant, equal to the word last written at that address.
- R10: A data-side request with the write enable set stores its write data in the addressed bank word, occupies that bank for its cycle, and raises no data-side valid flag.
- R11: A 32-iteration sequence of dual operand reads, with fetch suppressed by the repeat input, takes 64 cycles when both operands lie in one bank and 32 cycles when they lie in different banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rpt_i | input | 1 | Repeat in progress; ignores the fetch request |
| fch_req_i | input | 1 | Fetch request |
| fch_addr_i | input | 16 | Fetch address |
| fch_rdata_o | output | 32 | Fetch read data |
| fch_rvalid_o | output | 1 | Fetch read data valid |
| fch_err_o | output | 1 | Fetch address hit no bank |
| dat_req_i | input | 1 | Data-side operand request |
| dat_we_i | input | 1 | Data-side write enable |
| dat_addr_i | input | 16 | Data-side address |
| dat_wdata_i | input | 32 | Data-side write data |
| dat_rdata_o | output | 32 | Data-side read data |
| dat_rvalid_o | output | 1 | Data-side read data valid |
| dat_err_o | output | 1 | Data-side address hit no bank |
| prg_req_i | input | 1 | Program-side operand read request |
| prg_addr_i | input | 16 | Program-side address |
| prg_rdata_o | output | 32 | Program-side read data |
| prg_rvalid_o | output | 1 | Program-side read data valid |
| prg_err_o | output | 1 | Program-side address hit no bank |
| stall_o | output | 1 | Pipeline stall: requests must be held |

## Verification
Operand serving and fetch serving can land in the same cycle and on the same bank, and the data-side write can meet a fetch in one cycle. A sweep walks the program-side address across every window, every gap and both outer edges. Alongside it, the data-side and fetch addresses are rotated across banks and the repeat input is toggled, so every pairing of two or three ports on one bank and on different banks occurs. For each access the bench ranks the colliding ports by priority, and from that rank it predicts the stall length, the cycle each valid flag appears and the word returned. It then compares those predictions with the ports, including the totals for both placements of a 32-iteration repeated dual read.

// File: rtl/bkarb_pkg.sv
package bkarb_pkg;

    // Requesting ports, in falling priority order.
    localparam int NPORT  = 3;
    localparam int IX_DAT = 0;
    localparam int IX_PRG = 1;
    localparam int IX_FCH = 2;

    typedef logic [NPORT-1:0] port_vec_t;

endpackage

// File: rtl/bkarb_decode.sv
module bkarb_decode #(
    parameter int ADDR_W      = 16,
    parameter int NUM_BANKS   = 4,
    parameter int BANK_WORDS  = 64,
    parameter int BANK_STRIDE = 128,
    parameter int BANK_BASE   = 32'h8000,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int OFF_W      = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [OFF_W-1:0]  off_o
);

    logic [NUM_BANKS-1:0]            match;
    logic [NUM_BANKS-1:0][OFF_W-1:0] rel;

    // One window comparator per bank: [lo, hi] inclusive.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(BANK_BASE + b * BANK_STRIDE);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(BANK_BASE + b * BANK_STRIDE + BANK_WORDS - 1);
        assign match[b] = (addr_i >= LO) && (addr_i <= HI);
        assign rel[b]   = OFF_W'(addr_i - LO);
    end

    always_comb begin
        hit_o  = |match;
        bank_o = '0;
        off_o  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (match[b]) begin
                bank_o = BANK_W'(b);
                off_o  = rel[b];
            end
        end
    end

endmodule

// File: rtl/bkarb_grant.sv
module bkarb_grant
    import bkarb_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  port_vec_t                    req_i,
    input  port_vec_t                    inr_i,
    input  logic [NPORT-1:0][BANK_W-1:0] bank_i,
    output port_vec_t                    grant_o,
    output port_vec_t                    err_o,
    output logic                         stall_o
);

    typedef struct packed {
        port_vec_t done;
    } gst_t;

    gst_t      st_d, st_q;
    port_vec_t pend, live;

    always_comb begin
        pend = req_i & ~st_q.done;
        live = pend & inr_i;
        // Fixed priority: a port loses to any lower-index live port on its bank.
        for (int p = 0; p < NPORT; p++) begin
            grant_o[p] = live[p];
            for (int q = 0; q < p; q++) begin
                if (live[q] && (bank_i[q] == bank_i[p])) begin
                    grant_o[p] = 1'b0;
                end
            end
        end
        err_o   = pend & ~inr_i;
        stall_o = |(live & ~grant_o);
        // The served mask lives only while the core holds its requests.
        st_d.done = stall_o ? (st_q.done | grant_o | err_o) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a stall needs at least two live requests competing.
    a_r4_stall_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> ($countones(live) >= 2));

    // R7: three ports can stall at most two cycles in a row.
    a_r7_stall_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |=> !stall_o);

endmodule

// File: rtl/bkarb_ram.sv
module bkarb_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Single port: one read or one write per cycle.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) mem_q[addr_i] <= wdata_i;
            else      rdata_q       <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/bkarb_top.sv
module bkarb_top
    import bkarb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_BANKS   = 4,
    parameter int BANK_WORDS  = 64,
    parameter int BANK_STRIDE = 128,
    parameter int BANK_BASE   = 32'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_i,
    input  logic              fch_req_i,
    input  logic [ADDR_W-1:0] fch_addr_i,
    output logic [DATA_W-1:0] fch_rdata_o,
    output logic              fch_rvalid_o,
    output logic              fch_err_o,
    input  logic              dat_req_i,
    input  logic              dat_we_i,
    input  logic [ADDR_W-1:0] dat_addr_i,
    input  logic [DATA_W-1:0] dat_wdata_i,
    output logic [DATA_W-1:0] dat_rdata_o,
    output logic              dat_rvalid_o,
    output logic              dat_err_o,
    input  logic              prg_req_i,
    input  logic [ADDR_W-1:0] prg_addr_i,
    output logic [DATA_W-1:0] prg_rdata_o,
    output logic              prg_rvalid_o,
    output logic              prg_err_o,
    output logic              stall_o
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int OFF_W  = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;

    typedef struct packed {
        port_vec_t                    rv;
        port_vec_t                    er;
        logic [NPORT-1:0][BANK_W-1:0] bk;
    } ost_t;

    logic [NPORT-1:0][ADDR_W-1:0] p_addr;
    logic [NPORT-1:0][BANK_W-1:0] p_bank;
    logic [NPORT-1:0][OFF_W-1:0]  p_off;
    port_vec_t                    p_hit, p_req, g_grant, g_err;
    logic [DATA_W-1:0]            b_rdata [NUM_BANKS];
    ost_t                         st_d, st_q;

    assign p_addr[IX_DAT] = dat_addr_i;
    assign p_addr[IX_PRG] = prg_addr_i;
    assign p_addr[IX_FCH] = fch_addr_i;
    assign p_req[IX_DAT]  = dat_req_i;
    assign p_req[IX_PRG]  = prg_req_i;
    assign p_req[IX_FCH]  = fch_req_i & ~rpt_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        bkarb_decode #(
            .ADDR_W      (ADDR_W),
            .NUM_BANKS   (NUM_BANKS),
            .BANK_WORDS  (BANK_WORDS),
            .BANK_STRIDE (BANK_STRIDE),
            .BANK_BASE   (BANK_BASE)
        ) dec_i (
            .addr_i (p_addr[p]),
            .hit_o  (p_hit[p]),
            .bank_o (p_bank[p]),
            .off_o  (p_off[p])
        );
    end

    bkarb_grant #(.BANK_W(BANK_W)) grant_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (p_req),
        .inr_i   (p_hit),
        .bank_i  (p_bank),
        .grant_o (g_grant),
        .err_o   (g_err),
        .stall_o (stall_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        port_vec_t         hit;
        logic              en, we;
        logic [OFF_W-1:0]  ad;

        always_comb begin
            for (int p = 0; p < NPORT; p++) begin
                hit[p] = g_grant[p] && (p_bank[p] == BANK_W'(b));
            end
            en = |hit;
            we = hit[IX_DAT] && dat_we_i;
            ad = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (hit[p]) ad = p_off[p];
            end
        end

        bkarb_ram #(.DATA_W(DATA_W), .DEPTH(BANK_WORDS)) ram_i (
            .clk     (clk),
            .en_i    (en),
            .we_i    (we),
            .addr_i  (ad),
            .wdata_i (dat_wdata_i),
            .rdata_o (b_rdata[b])
        );

        // R3: one access per bank per cycle.
        a_r3_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= 1);
    end

    // Return path: valid, error and bank tag per port, one cycle behind the grant.
    always_comb begin
        st_d    = st_q;
        st_d.rv = g_grant & ~port_vec_t'({2'b00, dat_we_i});
        st_d.er = g_err;
        for (int p = 0; p < NPORT; p++) begin
            if (g_grant[p]) st_d.bk[p] = p_bank[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dat_rvalid_o = st_q.rv[IX_DAT];
    assign prg_rvalid_o = st_q.rv[IX_PRG];
    assign fch_rvalid_o = st_q.rv[IX_FCH];
    assign dat_err_o    = st_q.er[IX_DAT];
    assign prg_err_o    = st_q.er[IX_PRG];
    assign fch_err_o    = st_q.er[IX_FCH];
    assign dat_rdata_o  = b_rdata[st_q.bk[IX_DAT]];
    assign prg_rdata_o  = b_rdata[st_q.bk[IX_PRG]];
    assign fch_rdata_o  = b_rdata[st_q.bk[IX_FCH]];

    // R9: a granted read returns valid on its own port next cycle.
    a_r9_dat_return: assert property (@(posedge clk) disable iff (!rst_n)
        (g_grant[IX_DAT] && !dat_we_i) |=> dat_rvalid_o);
    a_r9_prg_return: assert property (@(posedge clk) disable iff (!rst_n)
        g_grant[IX_PRG] |=> prg_rvalid_o);

    // R2: an error never comes with valid data on the same port.
    a_r2_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_err_o && dat_rvalid_o) && !(prg_err_o && prg_rvalid_o) && !(fch_err_o && fch_rvalid_o));

    // R8: no fetch response follows a repeat cycle.
    a_r8_rpt_quiet_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_i |=> (!fch_rvalid_o && !fch_err_o));

endmodule

// File: tb/bkarb_top_tb_top.sv
`timescale 1ns/1ps
module bkarb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_i = 1'b0;
    logic        fch_req_i = 1'b0, dat_req_i = 1'b0, dat_we_i = 1'b0, prg_req_i = 1'b0;
    logic [15:0] fch_addr_i = '0, dat_addr_i = '0, prg_addr_i = '0;
    logic [31:0] dat_wdata_i = '0;
    logic [31:0] fch_rdata_o, dat_rdata_o, prg_rdata_o;
    logic        fch_rvalid_o, dat_rvalid_o, prg_rvalid_o;
    logic        fch_err_o, dat_err_o, prg_err_o, stall_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] mdl [256];

    always #4 clk = ~clk;

    bkarb_top dut_i (
        .clk(clk), .rst_n(rst_n), .rpt_i(rpt_i),
        .fch_req_i(fch_req_i), .fch_addr_i(fch_addr_i), .fch_rdata_o(fch_rdata_o),
        .fch_rvalid_o(fch_rvalid_o), .fch_err_o(fch_err_o),
        .dat_req_i(dat_req_i), .dat_we_i(dat_we_i), .dat_addr_i(dat_addr_i),
        .dat_wdata_i(dat_wdata_i), .dat_rdata_o(dat_rdata_o),
        .dat_rvalid_o(dat_rvalid_o), .dat_err_o(dat_err_o),
        .prg_req_i(prg_req_i), .prg_addr_i(prg_addr_i), .prg_rdata_o(prg_rdata_o),
        .prg_rvalid_o(prg_rvalid_o), .prg_err_o(prg_err_o),
        .stall_o(stall_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1 window model: bank i spans 0x8000+0x80*i .. +0x3F.
    function automatic bit in_rng(input logic [15:0] a);
        for (int b = 0; b < 4; b++) begin
            if (a >= 16'h8000 + 16'(b * 128) && a <= 16'h803F + 16'(b * 128)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int bank_of(input logic [15:0] a);
        return int'(a - 16'h8000) / 128;
    endfunction

    function automatic int idx_of(input logic [15:0] a);
        return bank_of(a) * 64 + int'(a - 16'h8000) % 128;
    endfunction

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a, a ^ 16'hA5C3};
    endfunction

    // Presents one set of requests, holds them while stalled, and checks
    // stall length, return cycle, data and error flags against the rank model.
    task automatic issue(input bit dreq, input bit dwe, input logic [15:0] da,
                         input logic [31:0] dwd, input bit preq, input logic [15:0] pa,
                         input bit freq, input logic [15:0] fa, input bit rpt,
                         output int ncyc);
        logic [15:0] ad [3];
        bit          eff [3];
        bit          ir [3];
        int          rank [3];
        int          rv_at [3];
        int          er_at [3];
        logic [31:0] rv_dat [3];
        bit          rvs [3];
        bit          ers [3];
        logic [31:0] rds [3];
        int          maxr, c, exp_at;
        bit          st;
        ad[0] = da; ad[1] = pa; ad[2] = fa;
        eff[0] = dreq; eff[1] = preq; eff[2] = freq && !rpt;
        maxr = 0;
        for (int p = 0; p < 3; p++) begin
            ir[p] = in_rng(ad[p]);
            rv_at[p] = -1; er_at[p] = -1; rv_dat[p] = '0;
            rank[p] = 0;
            for (int q = 0; q < p; q++) begin
                if (eff[q] && ir[q] && eff[p] && ir[p] && bank_of(ad[q]) == bank_of(ad[p])) rank[p]++;
            end
            if (eff[p] && ir[p] && rank[p] > maxr) maxr = rank[p];
        end
        dat_req_i = dreq; dat_we_i = dwe; dat_addr_i = da; dat_wdata_i = dwd;
        prg_req_i = preq; prg_addr_i = pa;
        fch_req_i = freq; fch_addr_i = fa; rpt_i = rpt;
        c = 0;
        forever begin
            #1 st = stall_o;
            @(posedge clk); #2;
            rvs[0] = dat_rvalid_o; rvs[1] = prg_rvalid_o; rvs[2] = fch_rvalid_o;
            ers[0] = dat_err_o;    ers[1] = prg_err_o;    ers[2] = fch_err_o;
            rds[0] = dat_rdata_o;  rds[1] = prg_rdata_o;  rds[2] = fch_rdata_o;
            for (int p = 0; p < 3; p++) begin
                if (rvs[p]) begin rv_at[p] = (rv_at[p] == -1) ? c : -2; rv_dat[p] = rds[p]; end
                if (ers[p]) er_at[p] = (er_at[p] == -1) ? c : -2;
            end
            if (!st || c > 6) break;
            c++;
        end
        ncyc = c + 1;
        chk(ncyc == maxr + 1, "R7 serialized cycle count", ncyc, maxr + 1);
        for (int p = 0; p < 3; p++) begin
            exp_at = (eff[p] && ir[p] && !(p == 0 && dwe)) ? rank[p] : -1;
            chk(rv_at[p] == exp_at, $sformatf("R9 return cycle port%0d", p), rv_at[p], exp_at);
            if (exp_at >= 0)
                chk(rv_dat[p] == mdl[idx_of(ad[p])], $sformatf("R9 data port%0d", p),
                    rv_dat[p], mdl[idx_of(ad[p])]);
            exp_at = (eff[p] && !ir[p]) ? 0 : -1;
            chk(er_at[p] == exp_at, $sformatf("R2 error flag port%0d", p), er_at[p], exp_at);
        end
        if (dreq && dwe && ir[0]) mdl[idx_of(da)] = dwd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, tot;
        logic [15:0] a;
        repeat (3) @(posedge clk);
        #2;
        chk(!stall_o && !dat_rvalid_o && !prg_rvalid_o && !fch_rvalid_o &&
            !dat_err_o && !prg_err_o && !fch_err_o, "reset outputs idle", 1, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R10: preload every bank word through the data-side write path.
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < 64; o++) begin
                a = 16'h8000 + 16'(b * 128 + o);
                issue(1, 1, a, pat(a), 0, 16'h0, 0, 16'h0, 0, n);
            end
        end

        // R1 R2 R4 R5 R6 R8: program-side address sweeps every window, gap and edge.
        for (int k = 0; k < 480; k++) begin
            a = 16'h7FF0 + 16'(k);
            issue(k % 7 != 0, 0, 16'h8000 + 16'((k % 4) * 128 + (k * 7) % 64), 32'h0,
                  1, a,
                  k % 3 != 0, 16'h8000 + 16'(((k / 4) % 4) * 128 + k % 64),
                  k % 5 == 0, n);
        end

        // R4: three ports, three banks.
        issue(1, 0, 16'h8001, 0, 1, 16'h8082, 1, 16'h8103, 0, n);
        chk(n == 1, "R4 parallel banks no stall", n, 1);
        // R5: both operands in bank 1.
        issue(1, 0, 16'h8090, 0, 1, 16'h80A0, 0, 16'h0, 0, n);
        chk(n == 2, "R5 operand collision", n, 2);
        // R6: fetch against data access in bank 2.
        issue(1, 0, 16'h8105, 0, 0, 16'h0, 1, 16'h8110, 0, n);
        chk(n == 2, "R6 fetch yields to data", n, 2);
        // R3 R7: all three in bank 3.
        issue(1, 0, 16'h8180, 0, 1, 16'h81BF, 1, 16'h81A0, 0, n);
        chk(n == 3, "R3 R7 three-way serialization", n, 3);
        // R8: same collision with repeat set drops the fetch.
        issue(1, 0, 16'h8180, 0, 1, 16'h81BF, 1, 16'h81A0, 1, n);
        chk(n == 2, "R8 fetch ignored in repeat", n, 2);
        // R10: write colliding with fetch, then read back.
        issue(1, 1, 16'h8111, 32'hDEADBEEF, 0, 16'h0, 1, 16'h8100, 0, n);
        chk(n == 2, "R10 write blocks fetch", n, 2);
        issue(0, 0, 16'h0, 0, 1, 16'h8111, 0, 16'h0, 0, n);
        chk(n == 1, "R10 readback", n, 1);

        // R11: repeated dual reads, same bank then split banks.
        tot = 0;
        for (int k = 0; k < 32; k++) begin
            issue(1, 0, 16'h8000 + 16'(k), 0, 1, 16'h8020 + 16'(k), 1, 16'h8010, 1, n);
            tot += n;
        end
        chk(tot == 64, "R11 same-bank repeat cycles", tot, 64);
        tot = 0;
        for (int k = 0; k < 32; k++) begin
            issue(1, 0, 16'h8000 + 16'(k), 0, 1, 16'h8080 + 16'(k), 1, 16'h8010, 1, n);
            tot += n;
        end
        chk(tot == 32, "R11 split-bank repeat cycles", tot, 32);

        dat_req_i = 0; prg_req_i = 0; fch_req_i = 0; rpt_i = 0;
        @(posedge clk); #2;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule